// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Victim Array

This block caches virtual-to-physical page translations for a processor front end. A direct-mapped primary array, indexed by the low bits of the virtual page number, is backed by a small fully associative victim array. The victim array catches translations that refills push out of the primary array. Both arrays exist once per MMU mode, and a lookup only searches the arrays of its own mode. Each entry holds three page tags (one each for read, write and fetch) and an offset that is added to the virtual address to form the physical address. An invalid entry has every tag field set to all ones.

A lookup first probes the primary slot. If that misses, the victim array is probed in the next cycle. A victim hit swaps the found entry with the primary slot, so the next access to that page hits in the primary array. A miss in both arrays raises a page-walk request, which stays high until the walker returns a translation on the refill port. A refill never discards the old primary entry: it moves that entry into a victim slot picked by a free-running LFSR. If several victim entries match, the lowest-numbered one is used. Maintenance inputs flush every entry in all modes, or flush one page from the primary and victim arrays of every mode. A virtual page whose number is all ones can never be cached, because that value is the invalid pattern.

Refill and flush commands are accepted while the block is idle or waiting for a walk. A lookup is accepted only while `lk_rdy` is high. When several commands arrive in the same cycle, full flush has priority, then page flush, then refill, then lookup.

Top module: `vtlb_top`

## Requirements
- R1: After reset, `lk_rdy`=1, `walk_req`=0 and `res_valid`=0, and every lookup misses in both arrays.
- R2: For a lookup accepted at clock edge N that hits in the primary array, `res_valid`=1 and `res_hit`=1 follow edge N+1, and `res_pa` = virtual address + stored offset (modulo 2^VA_W). `lk_rdy` is low from edge N until the result.
- R3: `lk_acc` 2'b00 compares the read tag, 2'b01 compares the write tag, and 2'b10 or 2'b11 compares the fetch tag. In `rf_perm`, bit 0 grants read, bit 1 grants write and bit 2 grants fetch. A permission bit that is clear leaves that tag invalid, so that access type misses.
- R4: A lookup that misses the primary slot but matches a victim entry of the same mode (using the tag for its access type) gives `res_valid`=1 and `res_hit`=1 after edge N+2, with the victim entry's offset, and no walk request.
- R5: A victim hit swaps the two entries. The found page then hits in the primary array, and the displaced primary page hits in the victim array.
- R6: A refill writes the new translation to primary slot (page mod SETS) of `rf_mode`. The previous contents of that slot move to the victim array of the same mode and stay retrievable.
- R7: A translation installed in one MMU mode is never returned for a lookup in another mode.
- R8: A miss in both arrays gives `res_valid`=1 and `res_hit`=0 after edge N+2. `walk_req` rises at that edge, and `walk_req` stays high while `lk_rdy` stays low until a refill is accepted. `walk_req` is low after that edge.
- R9: A full flush invalidates every primary and victim entry of every mode.
- R10: A page flush invalidates the entries whose read, write or fetch tag equals the page, in the primary slot and all victim entries of every mode. Other entries are kept.
- R11: The primary slot is the low log2(SETS) bits of the virtual page number. Pages with different slot bits coexist in the primary array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; invalidates all entries |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 1x fetch |
| lk_mode | input | MODE_W | MMU mode of the lookup |
| lk_rdy | output | 1 | Block can accept a lookup |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Result is a hit |
| res_pa | output | VA_W | Translated address on a hit, zero on a miss |
| walk_req | output | 1 | Page walk needed; held until a refill |
| rf_valid | input | 1 | Refill command |
| rf_page | input | VPN_W | Virtual page number being installed |
| rf_mode | input | MODE_W | MMU mode of the refill |
| rf_perm | input | 3 | Granted access: bit0 read, bit1 write, bit2 fetch |
| rf_ofs | input | VA_W | Offset added to the virtual address |
| fl_all | input | 1 | Flush every entry |
| fl_page | input | 1 | Flush one page |
| fl_vpn | input | VPN_W | Page number to flush |

## Verification
The assertions watch the handshake on every cycle. They check that results are single-cycle strobes and that a miss result always comes with a walk request. They check that `walk_req` rises only on a miss result, holds until a refill and drops after it. They also check that `lk_rdy` falls after every accepted lookup and stays low during a walk. The contents of the arrays can only be seen through scenarios in the bench. Those scenarios cover the swap on a victim hit, eviction into the victim array on refill, tag selection by access type, isolation between modes, and exactly which entries a page flush removes. Result latency separates primary hits from victim hits.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_VICT  = 2'd2,
    ST_WAIT  = 2'd3
  } vtlb_state_e;

  typedef enum logic [1:0] {
    ACC_READ   = 2'b00,
    ACC_WRITE  = 2'b01,
    ACC_FETCH  = 2'b10,
    ACC_FETCH2 = 2'b11
  } vtlb_acc_e;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_FX = 2;

endpackage

// File: rtl/vtlb_lfsr.sv
module vtlb_lfsr #(
  parameter int           W     = 16,
  parameter logic [W-1:0] TAPS  = 16'hB400,
  parameter logic [W-1:0] SEED  = 16'hACE1,
  parameter int           OUT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);

  logic [W-1:0] state;

  // Galois form, advances every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (state[0]) begin
      state <= (state >> 1) ^ TAPS;
    end else begin
      state <= state >> 1;
    end
  end

  assign rnd = state[OUT_W-1:0];

endmodule

// File: rtl/vtlb_pri_array.sv
module vtlb_pri_array #(
  parameter int  MODES  = 2,
  parameter int  SETS   = 256,
  parameter int  VPN_W  = 20,
  parameter int  OFS_W  = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int MODE_W = (MODES > 1) ? $clog2(MODES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_all,
  input  logic              pf_en,
  input  logic [VPN_W-1:0]  pf_vpn,
  // registered read for lookups
  input  logic              rd_en,
  input  logic [MODE_W-1:0] rd_mode,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN_W-1:0]  q_rt,
  output logic [VPN_W-1:0]  q_wt,
  output logic [VPN_W-1:0]  q_ct,
  output logic [OFS_W-1:0]  q_ofs,
  // combinational read of the slot a refill displaces
  input  logic [MODE_W-1:0] ev_mode,
  input  logic [IDX_W-1:0]  ev_idx,
  output logic [VPN_W-1:0]  ev_rt,
  output logic [VPN_W-1:0]  ev_wt,
  output logic [VPN_W-1:0]  ev_ct,
  output logic [OFS_W-1:0]  ev_ofs,
  // write port
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_rt,
  input  logic [VPN_W-1:0]  wr_wt,
  input  logic [VPN_W-1:0]  wr_ct,
  input  logic [OFS_W-1:0]  wr_ofs
);

  logic [VPN_W-1:0] rt_mem  [MODES][SETS];
  logic [VPN_W-1:0] wt_mem  [MODES][SETS];
  logic [VPN_W-1:0] ct_mem  [MODES][SETS];
  logic [OFS_W-1:0] ofs_mem [MODES][SETS];

  logic [IDX_W-1:0] pf_idx;
  logic [MODES-1:0] pf_hit;

  assign pf_idx = pf_vpn[IDX_W-1:0];

  for (genvar m = 0; m < MODES; m++) begin : g_pf
    assign pf_hit[m] = (rt_mem[m][pf_idx] == pf_vpn) ||
                       (wt_mem[m][pf_idx] == pf_vpn) ||
                       (ct_mem[m][pf_idx] == pf_vpn);
  end

  always_ff @(posedge clk) begin
    if (rst || flush_all) begin
      for (int m = 0; m < MODES; m++) begin
        for (int s = 0; s < SETS; s++) begin
          rt_mem[m][s]  <= '1;
          wt_mem[m][s]  <= '1;
          ct_mem[m][s]  <= '1;
          ofs_mem[m][s] <= '1;
        end
      end
    end else begin
      if (pf_en) begin
        for (int m = 0; m < MODES; m++) begin
          if (pf_hit[m]) begin
            rt_mem[m][pf_idx]  <= '1;
            wt_mem[m][pf_idx]  <= '1;
            ct_mem[m][pf_idx]  <= '1;
            ofs_mem[m][pf_idx] <= '1;
          end
        end
      end
      if (wr_en) begin
        rt_mem[wr_mode][wr_idx]  <= wr_rt;
        wt_mem[wr_mode][wr_idx]  <= wr_wt;
        ct_mem[wr_mode][wr_idx]  <= wr_ct;
        ofs_mem[wr_mode][wr_idx] <= wr_ofs;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_rt  <= '1;
      q_wt  <= '1;
      q_ct  <= '1;
      q_ofs <= '1;
    end else if (rd_en) begin
      q_rt  <= rt_mem[rd_mode][rd_idx];
      q_wt  <= wt_mem[rd_mode][rd_idx];
      q_ct  <= ct_mem[rd_mode][rd_idx];
      q_ofs <= ofs_mem[rd_mode][rd_idx];
    end
  end

  assign ev_rt  = rt_mem[ev_mode][ev_idx];
  assign ev_wt  = wt_mem[ev_mode][ev_idx];
  assign ev_ct  = ct_mem[ev_mode][ev_idx];
  assign ev_ofs = ofs_mem[ev_mode][ev_idx];

endmodule

// File: rtl/vtlb_vic_array.sv
module vtlb_vic_array
  import vtlb_pkg::*;
#(
  parameter int  MODES  = 2,
  parameter int  WAYS   = 8,
  parameter int  VPN_W  = 20,
  parameter int  OFS_W  = 32,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int MODE_W = (MODES > 1) ? $clog2(MODES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_all,
  input  logic              pf_en,
  input  logic [VPN_W-1:0]  pf_vpn,
  // associative probe
  input  logic [MODE_W-1:0] pr_mode,
  input  logic [1:0]        pr_acc,
  input  logic [VPN_W-1:0]  pr_vpn,
  output logic              pr_hit,
  output logic [WAY_W-1:0]  pr_way,
  output logic [VPN_W-1:0]  pr_rt,
  output logic [VPN_W-1:0]  pr_wt,
  output logic [VPN_W-1:0]  pr_ct,
  output logic [OFS_W-1:0]  pr_ofs,
  // write port
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [VPN_W-1:0]  wr_rt,
  input  logic [VPN_W-1:0]  wr_wt,
  input  logic [VPN_W-1:0]  wr_ct,
  input  logic [OFS_W-1:0]  wr_ofs
);

  logic [VPN_W-1:0] rt_mem  [MODES][WAYS];
  logic [VPN_W-1:0] wt_mem  [MODES][WAYS];
  logic [VPN_W-1:0] ct_mem  [MODES][WAYS];
  logic [OFS_W-1:0] ofs_mem [MODES][WAYS];

  logic [WAYS-1:0] match;
  logic [MODES-1:0][WAYS-1:0] pf_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VPN_W-1:0] tag;
    always_comb begin
      unique case (vtlb_acc_e'(pr_acc))
        ACC_READ:  tag = rt_mem[pr_mode][w];
        ACC_WRITE: tag = wt_mem[pr_mode][w];
        default:   tag = ct_mem[pr_mode][w];
      endcase
    end
    assign match[w] = (tag == pr_vpn);
    for (genvar m = 0; m < MODES; m++) begin : g_mode
      assign pf_hit[m][w] = (rt_mem[m][w] == pf_vpn) ||
                            (wt_mem[m][w] == pf_vpn) ||
                            (ct_mem[m][w] == pf_vpn);
    end
  end

  // lowest-numbered matching way wins
  always_comb begin
    pr_hit = 1'b0;
    pr_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        pr_hit = 1'b1;
        pr_way = WAY_W'(w);
      end
    end
  end

  assign pr_rt  = rt_mem[pr_mode][pr_way];
  assign pr_wt  = wt_mem[pr_mode][pr_way];
  assign pr_ct  = ct_mem[pr_mode][pr_way];
  assign pr_ofs = ofs_mem[pr_mode][pr_way];

  always_ff @(posedge clk) begin
    if (rst || flush_all) begin
      for (int m = 0; m < MODES; m++) begin
        for (int w = 0; w < WAYS; w++) begin
          rt_mem[m][w]  <= '1;
          wt_mem[m][w]  <= '1;
          ct_mem[m][w]  <= '1;
          ofs_mem[m][w] <= '1;
        end
      end
    end else begin
      if (pf_en) begin
        for (int m = 0; m < MODES; m++) begin
          for (int w = 0; w < WAYS; w++) begin
            if (pf_hit[m][w]) begin
              rt_mem[m][w]  <= '1;
              wt_mem[m][w]  <= '1;
              ct_mem[m][w]  <= '1;
              ofs_mem[m][w] <= '1;
            end
          end
        end
      end
      if (wr_en) begin
        rt_mem[wr_mode][wr_way]  <= wr_rt;
        wt_mem[wr_mode][wr_way]  <= wr_wt;
        ct_mem[wr_mode][wr_way]  <= wr_ct;
        ofs_mem[wr_mode][wr_way] <= wr_ofs;
      end
    end
  end

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
  import vtlb_pkg::*;
#(
  parameter int          VA_W      = 32,
  parameter int          PAGE_BITS = 12,
  parameter int          SETS      = 256,
  parameter int          WAYS      = 8,
  parameter int          MODES     = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         VPN_W     = VA_W - PAGE_BITS,
  localparam int         MODE_W    = (MODES > 1) ? $clog2(MODES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [1:0]        lk_acc,
  input  logic [MODE_W-1:0] lk_mode,
  output logic              lk_rdy,
  output logic              res_valid,
  output logic              res_hit,
  output logic [VA_W-1:0]   res_pa,
  output logic              walk_req,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_page,
  input  logic [MODE_W-1:0] rf_mode,
  input  logic [2:0]        rf_perm,
  input  logic [VA_W-1:0]   rf_ofs,
  input  logic              fl_all,
  input  logic              fl_page,
  input  logic [VPN_W-1:0]  fl_vpn
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int OFS_W = VA_W;

  vtlb_state_e st;

  logic cmd_ok, do_fa, do_fp, do_rf, do_lk;
  logic [VPN_W-1:0] lk_vpn;

  // latched request
  logic [VPN_W-1:0]     r_vpn;
  logic [PAGE_BITS-1:0] r_off;
  vtlb_acc_e            r_acc;
  logic [MODE_W-1:0]    r_mode;
  logic [VA_W-1:0]      r_va;

  // primary read data
  logic [VPN_W-1:0] q_rt, q_wt, q_ct, p_tag;
  logic [OFS_W-1:0] q_ofs;
  logic [VPN_W-1:0] ev_rt, ev_wt, ev_ct;
  logic [OFS_W-1:0] ev_ofs;
  logic             p_hit;

  // victim probe, live and registered
  logic             pr_hit;
  logic [WAY_W-1:0] pr_way;
  logic [VPN_W-1:0] pr_rt, pr_wt, pr_ct;
  logic [OFS_W-1:0] pr_ofs;
  logic             vq_hit;
  logic [WAY_W-1:0] vq_way;
  logic [VPN_W-1:0] vq_rt, vq_wt, vq_ct;
  logic [OFS_W-1:0] vq_ofs;

  logic [WAY_W-1:0] rnd_way;
  logic             swap_go;

  // write-port muxes
  logic              wr_en;
  logic [MODE_W-1:0] wr_mode;
  logic [IDX_W-1:0]  pri_idx;
  logic [WAY_W-1:0]  vic_way;
  logic [VPN_W-1:0]  pw_rt, pw_wt, pw_ct, vw_rt, vw_wt, vw_ct;
  logic [OFS_W-1:0]  pw_ofs, vw_ofs;

  assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];
  assign cmd_ok = (st == ST_IDLE) || (st == ST_WAIT);
  assign do_fa  = fl_all && cmd_ok;
  assign do_fp  = fl_page && cmd_ok && !fl_all;
  assign do_rf  = rf_valid && cmd_ok && !fl_all && !fl_page;
  assign do_lk  = lk_valid && (st == ST_IDLE) && !fl_all && !fl_page && !rf_valid;
  assign lk_rdy = (st == ST_IDLE);
  assign r_va   = {r_vpn, r_off};

  always_comb begin
    unique case (r_acc)
      ACC_READ:  p_tag = q_rt;
      ACC_WRITE: p_tag = q_wt;
      default:   p_tag = q_ct;
    endcase
  end
  assign p_hit = (p_tag == r_vpn);

  assign swap_go = (st == ST_VICT) && vq_hit;
  assign wr_en   = do_rf || swap_go;
  assign wr_mode = swap_go ? r_mode : rf_mode;
  assign pri_idx = swap_go ? r_vpn[IDX_W-1:0] : rf_page[IDX_W-1:0];
  assign vic_way = swap_go ? vq_way : rnd_way;

  // new primary contents: the victim entry on a swap, else the refill
  assign pw_rt  = swap_go ? vq_rt  : (rf_perm[PERM_RD] ? rf_page : '1);
  assign pw_wt  = swap_go ? vq_wt  : (rf_perm[PERM_WR] ? rf_page : '1);
  assign pw_ct  = swap_go ? vq_ct  : (rf_perm[PERM_FX] ? rf_page : '1);
  assign pw_ofs = swap_go ? vq_ofs : rf_ofs;

  // new victim contents: always the displaced primary entry
  assign vw_rt  = swap_go ? q_rt  : ev_rt;
  assign vw_wt  = swap_go ? q_wt  : ev_wt;
  assign vw_ct  = swap_go ? q_ct  : ev_ct;
  assign vw_ofs = swap_go ? q_ofs : ev_ofs;

  vtlb_lfsr #(
    .W    (16),
    .TAPS (16'hB400),
    .SEED (LFSR_SEED),
    .OUT_W(WAY_W)
  ) u_lfsr (
    .clk(clk),
    .rst(rst),
    .rnd(rnd_way)
  );

  vtlb_pri_array #(
    .MODES(MODES), .SETS(SETS), .VPN_W(VPN_W), .OFS_W(OFS_W)
  ) u_pri (
    .clk      (clk),
    .rst      (rst),
    .flush_all(do_fa),
    .pf_en    (do_fp),
    .pf_vpn   (fl_vpn),
    .rd_en    (do_lk),
    .rd_mode  (lk_mode),
    .rd_idx   (lk_vpn[IDX_W-1:0]),
    .q_rt     (q_rt),
    .q_wt     (q_wt),
    .q_ct     (q_ct),
    .q_ofs    (q_ofs),
    .ev_mode  (rf_mode),
    .ev_idx   (rf_page[IDX_W-1:0]),
    .ev_rt    (ev_rt),
    .ev_wt    (ev_wt),
    .ev_ct    (ev_ct),
    .ev_ofs   (ev_ofs),
    .wr_en    (wr_en),
    .wr_mode  (wr_mode),
    .wr_idx   (pri_idx),
    .wr_rt    (pw_rt),
    .wr_wt    (pw_wt),
    .wr_ct    (pw_ct),
    .wr_ofs   (pw_ofs)
  );

  vtlb_vic_array #(
    .MODES(MODES), .WAYS(WAYS), .VPN_W(VPN_W), .OFS_W(OFS_W)
  ) u_vic (
    .clk      (clk),
    .rst      (rst),
    .flush_all(do_fa),
    .pf_en    (do_fp),
    .pf_vpn   (fl_vpn),
    .pr_mode  (r_mode),
    .pr_acc   (r_acc),
    .pr_vpn   (r_vpn),
    .pr_hit   (pr_hit),
    .pr_way   (pr_way),
    .pr_rt    (pr_rt),
    .pr_wt    (pr_wt),
    .pr_ct    (pr_ct),
    .pr_ofs   (pr_ofs),
    .wr_en    (wr_en),
    .wr_mode  (wr_mode),
    .wr_way   (vic_way),
    .wr_rt    (vw_rt),
    .wr_wt    (vw_wt),
    .wr_ct    (vw_ct),
    .wr_ofs   (vw_ofs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pa    <= '0;
      walk_req  <= 1'b0;
      r_vpn     <= '0;
      r_off     <= '0;
      r_acc     <= ACC_READ;
      r_mode    <= '0;
      vq_hit    <= 1'b0;
      vq_way    <= '0;
      vq_rt     <= '1;
      vq_wt     <= '1;
      vq_ct     <= '1;
      vq_ofs    <= '1;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (do_lk) begin
            r_vpn  <= lk_vpn;
            r_off  <= lk_va[PAGE_BITS-1:0];
            r_acc  <= vtlb_acc_e'(lk_acc);
            r_mode <= lk_mode;
            st     <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (p_hit) begin
            res_valid <= 1'b1;
            res_hit   <= 1'b1;
            res_pa    <= r_va + q_ofs;
            st        <= ST_IDLE;
          end else begin
            vq_hit <= pr_hit;
            vq_way <= pr_way;
            vq_rt  <= pr_rt;
            vq_wt  <= pr_wt;
            vq_ct  <= pr_ct;
            vq_ofs <= pr_ofs;
            st     <= ST_VICT;
          end
        end
        ST_VICT: begin
          res_valid <= 1'b1;
          if (vq_hit) begin
            res_hit <= 1'b1;
            res_pa  <= r_va + vq_ofs;
            st      <= ST_IDLE;
          end else begin
            res_hit  <= 1'b0;
            res_pa   <= '0;
            walk_req <= 1'b1;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (do_rf) begin
            walk_req <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk (
  input logic clk,
  input logic rst,
  input logic lk_valid,
  input logic lk_rdy,
  input logic res_valid,
  input logic res_hit,
  input logic walk_req,
  input logic rf_valid,
  input logic fl_all,
  input logic fl_page
);

  logic rf_take, lk_take;
  assign rf_take = rf_valid && !fl_all && !fl_page;
  assign lk_take = lk_valid && lk_rdy && !fl_all && !fl_page && !rf_valid;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (lk_rdy && !walk_req && !res_valid));

  // R2
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    lk_take |=> !lk_rdy);

  // R8
  miss_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> walk_req);

  // R8
  walk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_req) |-> (res_valid && !res_hit));

  // R8
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !rf_take) |=> walk_req);

  // R8
  walk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && rf_take) |=> !walk_req);

  // R8
  walk_block_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> !lk_rdy);

  // R4
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> !walk_req);

endmodule

bind vtlb_top vtlb_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_valid (lk_valid),
  .lk_rdy   (lk_rdy),
  .res_valid(res_valid),
  .res_hit  (res_hit),
  .walk_req (walk_req),
  .rf_valid (rf_valid),
  .fl_all   (fl_all),
  .fl_page  (fl_page)
);

// File: tb/tb_vtlb_top.sv
module tb_vtlb_top;

  localparam int VA_W  = 32;
  localparam int VPN_W = 20;

  logic            clk = 1'b0;
  logic            rst;
  logic            lk_valid;
  logic [31:0]     lk_va;
  logic [1:0]      lk_acc;
  logic [0:0]      lk_mode;
  logic            lk_rdy;
  logic            res_valid;
  logic            res_hit;
  logic [31:0]     res_pa;
  logic            walk_req;
  logic            rf_valid;
  logic [19:0]     rf_page;
  logic [0:0]      rf_mode;
  logic [2:0]      rf_perm;
  logic [31:0]     rf_ofs;
  logic            fl_all;
  logic            fl_page;
  logic [19:0]     fl_vpn;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vtlb_top dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_acc(lk_acc), .lk_mode(lk_mode),
    .lk_rdy(lk_rdy), .res_valid(res_valid), .res_hit(res_hit), .res_pa(res_pa),
    .walk_req(walk_req),
    .rf_valid(rf_valid), .rf_page(rf_page), .rf_mode(rf_mode),
    .rf_perm(rf_perm), .rf_ofs(rf_ofs),
    .fl_all(fl_all), .fl_page(fl_page), .fl_vpn(fl_vpn)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 lookup, 1 refill, 2 flush all, 3 flush page
    logic        mode;
    logic [31:0] va;
    logic [1:0]  acc;
    logic [2:0]  perm;
    logic [31:0] ofs;   // refill offset, or expected offset for a hit
    logic        hit;
    logic [2:0]  lat;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] PA = 32'h0000_5123;  // slot 5
  localparam logic [31:0] PB = 32'h0010_5ABC;  // slot 5
  localparam logic [31:0] PC = 32'h0020_5000;  // slot 5
  localparam logic [31:0] PD = 32'h0000_6010;  // slot 6
  localparam logic [31:0] OA = 32'h1000_0000;
  localparam logic [31:0] OB = 32'h2000_0000;
  localparam logic [31:0] OD = 32'h0300_0000;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, PA, 2'd0, 3'b000, 32'h0, 1'b0, 3'd2, 4'd1},  // R1 empty
    '{2'd1, 1'b0, PA, 2'd0, 3'b011, OA,    1'b0, 3'd0, 4'd6},
    '{2'd0, 1'b0, PA, 2'd0, 3'b000, OA,    1'b1, 3'd1, 4'd2},  // R2
    '{2'd0, 1'b0, PA, 2'd1, 3'b000, OA,    1'b1, 3'd1, 4'd3},  // R3 write tag
    '{2'd0, 1'b0, PA, 2'd2, 3'b000, 32'h0, 1'b0, 3'd2, 4'd3},  // R3 no fetch
    '{2'd1, 1'b0, PA, 2'd0, 3'b111, OA,    1'b0, 3'd0, 4'd6},
    '{2'd0, 1'b0, PA, 2'd2, 3'b000, OA,    1'b1, 3'd1, 4'd3},  // R3 fetch
    '{2'd0, 1'b1, PA, 2'd0, 3'b000, 32'h0, 1'b0, 3'd2, 4'd7},  // R7
    '{2'd1, 1'b1, PD, 2'd0, 3'b001, OD,    1'b0, 3'd0, 4'd7},
    '{2'd0, 1'b1, PD, 2'd0, 3'b000, OD,    1'b1, 3'd1, 4'd7},  // R7
    '{2'd0, 1'b1, PD, 2'd1, 3'b000, 32'h0, 1'b0, 3'd2, 4'd3},  // R3 no write
    '{2'd1, 1'b1, PD, 2'd0, 3'b011, OD,    1'b0, 3'd0, 4'd6},
    '{2'd0, 1'b0, PD, 2'd0, 3'b000, 32'h0, 1'b0, 3'd2, 4'd7},  // R7
    '{2'd1, 1'b0, PD, 2'd0, 3'b001, OD,    1'b0, 3'd0, 4'd6},
    '{2'd0, 1'b0, PD, 2'd0, 3'b000, OD,    1'b1, 3'd1, 4'd11}, // R11
    '{2'd0, 1'b0, PA, 2'd0, 3'b000, OA,    1'b1, 3'd1, 4'd11}, // R11
    '{2'd1, 1'b0, PB, 2'd0, 3'b001, OB,    1'b0, 3'd0, 4'd6},
    '{2'd0, 1'b0, PB, 2'd0, 3'b000, OB,    1'b1, 3'd1, 4'd6},  // R6
    '{2'd0, 1'b0, PA, 2'd2, 3'b000, OA,    1'b1, 3'd2, 4'd4},  // R4 victim
    '{2'd0, 1'b0, PA, 2'd2, 3'b000, OA,    1'b1, 3'd1, 4'd5},  // R5 swapped in
    '{2'd0, 1'b0, PB, 2'd0, 3'b000, OB,    1'b1, 3'd2, 4'd5},  // R5 swapped out
    '{2'd3, 1'b0, PA, 2'd0, 3'b000, 32'h0, 1'b0, 3'd0, 4'd10},
    '{2'd0, 1'b0, PA, 2'd0, 3'b000, 32'h0, 1'b0, 3'd2, 4'd10}, // R10
    '{2'd1, 1'b0, PC, 2'd0, 3'b001, OA,    1'b0, 3'd0, 4'd6},
    '{2'd0, 1'b0, PC, 2'd0, 3'b000, OA,    1'b1, 3'd1, 4'd6},  // R6
    '{2'd0, 1'b1, PD, 2'd0, 3'b000, OD,    1'b1, 3'd1, 4'd10}, // R10 kept
    '{2'd0, 1'b0, PB, 2'd0, 3'b000, OB,    1'b1, 3'd2, 4'd6},  // R6 evicted
    '{2'd2, 1'b0, 32'h0, 2'd0, 3'b000, 32'h0, 1'b0, 3'd0, 4'd9},
    '{2'd0, 1'b1, PD, 2'd0, 3'b000, 32'h0, 1'b0, 3'd2, 4'd9},  // R9
    '{2'd1, 1'b1, PD, 2'd0, 3'b001, OD,    1'b0, 3'd0, 4'd6},
    '{2'd0, 1'b0, PC, 2'd0, 3'b000, 32'h0, 1'b0, 3'd2, 4'd9},  // R9
    '{2'd1, 1'b0, PC, 2'd0, 3'b001, OA,    1'b0, 3'd0, 4'd6},
    '{2'd0, 1'b0, PC, 2'd0, 3'b000, OA,    1'b1, 3'd1, 4'd2},  // R2
    '{2'd3, 1'b0, PD, 2'd0, 3'b000, 32'h0, 1'b0, 3'd0, 4'd10},
    '{2'd0, 1'b1, PD, 2'd0, 3'b000, 32'h0, 1'b0, 3'd2, 4'd10}, // R10 other mode
    '{2'd1, 1'b1, PD, 2'd0, 3'b001, OD,    1'b0, 3'd0, 4'd6}
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_va = '0; lk_acc = '0; lk_mode = '0;
    rf_valid = 0; rf_page = '0; rf_mode = '0; rf_perm = '0; rf_ofs = '0;
    fl_all = 0; fl_page = 0; fl_vpn = '0;
  endtask

  task automatic do_lookup(input logic m, input logic [31:0] va, input logic [1:0] acc,
                           input logic eh, input int elat, input logic [31:0] eofs,
                           input int rq);
    int lat;
    logic hit;
    logic [31:0] pa;
    lat = 0; hit = 0; pa = '0;
    @(negedge clk);
    chk(lk_rdy, rq, "lk_rdy before lookup", {31'd0, lk_rdy}, 32'd1);
    lk_valid = 1; lk_va = va; lk_acc = acc; lk_mode = m;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
    chk(!lk_rdy, rq, "lk_rdy while busy", {31'd0, lk_rdy}, 32'd0);
    for (int i = 1; i <= 4; i++) begin
      if (lat == 0) begin
        @(negedge clk);
        if (res_valid) begin
          lat = i; hit = res_hit; pa = res_pa;
          if (!eh) chk(walk_req && !lk_rdy, 8, "walk_req on double miss",
                       {30'd0, walk_req, lk_rdy}, 32'd2);
        end
      end
    end
    chk(lat == elat, rq, "result latency", lat, elat);
    chk(hit == eh, rq, "hit flag", {31'd0, hit}, {31'd0, eh});
    if (eh) chk(pa == va + eofs, rq, "physical address", pa, va + eofs);
  endtask

  task automatic do_refill(input logic m, input logic [31:0] va, input logic [2:0] perm,
                           input logic [31:0] ofs);
    @(negedge clk);
    rf_valid = 1; rf_page = va[31:12]; rf_mode = m; rf_perm = perm; rf_ofs = ofs;
    @(posedge clk);
    @(negedge clk);
    rf_valid = 0;
  endtask

  task automatic do_flush(input bit all, input logic [31:0] va);
    @(negedge clk);
    fl_all = all; fl_page = !all; fl_vpn = va[31:12];
    @(posedge clk);
    @(negedge clk);
    fl_all = 0; fl_page = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state at the ports
    chk(lk_rdy && !walk_req && !res_valid, 1, "reset state",
        {29'd0, lk_rdy, walk_req, res_valid}, 32'd4);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: do_lookup(VEC[i].mode, VEC[i].va, VEC[i].acc, VEC[i].hit,
                        int'(VEC[i].lat), VEC[i].ofs, int'(VEC[i].req));
        2'd1: do_refill(VEC[i].mode, VEC[i].va, VEC[i].perm, VEC[i].ofs);
        2'd2: do_flush(1'b1, VEC[i].va);
        default: do_flush(1'b0, VEC[i].va);
      endcase
    end

    // R8 walk request holds until a refill arrives
    do_lookup(1'b0, 32'h0ABC_D000, 2'd0, 1'b0, 2, 32'h0, 8);
    begin
      bit held;
      held = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!walk_req || lk_rdy) held = 0;
      end
      chk(held, 8, "walk_req held, lk_rdy low", {31'd0, held}, 32'd1);
    end
    do_refill(1'b0, 32'h0ABC_D000, 3'b001, 32'h0000_1000);
    chk(!walk_req && lk_rdy, 8, "walk_req cleared by refill",
        {30'd0, walk_req, lk_rdy}, 32'd1);
    do_lookup(1'b0, 32'h0ABC_D004, 2'd0, 1'b1, 1, 32'h0000_1000, 8);

    // R1 reset in mid-run empties the arrays
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    do_lookup(1'b0, 32'h0ABC_D004, 2'd0, 1'b0, 2, 32'h0, 1);
    do_refill(1'b0, 32'h0ABC_D000, 3'b001, 32'h0);

    summary();
    $finish;
  end

endmodule